// File: doc/BRIEF.md
# Multi-Mode Convolution Operand Sequencer

This block produces the read order that feeds a parallel multiply array for three kinds of convolution: 1x1 (pointwise), per-channel 3x3 (depthwise) and full 3x3 (normal). A start pulse captures the feature-map size (channels, rows, columns), the number of kernels and a mode code. The block then emits one operand beat per accepted handshake. Each beat carries a feature-buffer address, a weight-buffer address, a lane mask that says which kernel lanes consume the same feature value, and a flag that marks the last operand of an output-pixel group.

Every mode runs through the same counter nest. The outer level is the output row, then the column, then the input channel, and the innermost level is the 3x3 tap. In pointwise mode the tap level collapses to one step at the window centre. Taps that fall outside the feature map become zero operands and cause no buffer read. The surrounding datapath holds the buffer contents and does the arithmetic.

Top module: `cs_operand_seq`

## Requirements
- R1: After reset, out_valid, done, fm_rd and fm_zero are 0 and lane_mask is all zero.
- R2: Mode code 0 (pointwise) visits pixels in row-major order and, for each pixel, channels 0..C-1. Each beat has fm_addr = ch*H*W + y*W + x and wt_addr = ch. grp_last is 1 on the beat with ch = C-1.
- R3: Mode code 1 (depthwise) visits pixels in row-major order, then channels, then taps 0..8, where tap = 3*ty + tx reads row y+ty-1 and column x+tx-1. wt_addr = ch*9 + tap, and grp_last is 1 on every beat with tap 8.
- R4: Mode code 2 (normal) uses the same traversal and addresses as R3. grp_last is 1 only on the beat with ch = C-1 and tap 8.
- R5: While out_valid is 1, a tap outside rows 0..H-1 or columns 0..W-1 gives fm_zero = 1, fm_rd = 0 and fm_addr = 0. An in-range tap gives fm_zero = 0 and fm_rd = 1, and its address stays below C*H*W.
- R6: In modes 0 and 2, lane_mask bits 0..K-1 are 1 and the rest are 0, for K in 1..LANES. In mode 1 only bit 0 is 1.
- R7: While out_valid is 1 and out_ready is 0, no beat is consumed. out_valid and all beat fields hold their values into the next cycle.
- R8: done is a one-cycle pulse in the cycle after the final beat of a run is accepted. out_valid is 0 in that cycle.
- R9: A start pulse during a run is ignored and the run continues unchanged. A start with mode code 3 starts no run and produces no done.
- R10: A run has exactly H*W*C beats in mode 0 and H*W*C*9 beats in modes 1 and 2. C, H, W must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a run when idle |
| mode_in | input | 2 | 0 pointwise, 1 depthwise, 2 normal, 3 reserved |
| c_in | input | DIM_W | Input channel count |
| h_in | input | DIM_W | Feature-map rows |
| w_in | input | DIM_W | Feature-map columns |
| k_in | input | LK_W | Kernel count (lanes used) |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_valid | output | 1 | Beat present |
| fm_addr | output | FA_W | Feature-buffer address |
| fm_rd | output | 1 | Feature-buffer read enable |
| fm_zero | output | 1 | Operand is a zero pad |
| wt_addr | output | WA_W | Weight index within each kernel |
| lane_mask | output | LANES | Lanes that take this feature value |
| grp_last | output | 1 | Last operand of an output-pixel group |
| done | output | 1 | Run complete pulse |

## Verification
The first beat of a run appears in the cycle after start is sampled. Each later beat appears in the cycle after the previous one is accepted. done rises in the cycle after the final acceptance and falls one cycle later. The bench drives inputs and samples outputs on the falling edge, so each check reads the beat that the preceding rising edge produced. It computes each expected beat from nested loops over rows, columns, channels and taps. On stalled cycles it reads the same beat twice, once with ready low and once after ready returns high.

// File: rtl/cs_pkg.sv
// Shared types for the convolution operand sequencer.
package cs_pkg;
    typedef enum logic [1:0] {
        MODE_PW  = 2'd0,
        MODE_DW  = 2'd1,
        MODE_CON = 2'd2,
        MODE_RSV = 2'd3
    } conv_mode_e;

    localparam int WIN_TAPS = 9;
endpackage

// File: rtl/cs_nest_counter.sv
// Nested wrap counters. Level 0 is the innermost level. Each level steps
// when every level inside it is at its limit.
// Assumes: lim changes only in the cycle of clear.
module cs_nest_counter #(
    parameter int LEVELS = 4,
    parameter int CW     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        step,
    input  logic [LEVELS-1:0][CW-1:0]   lim,
    output logic [LEVELS-1:0][CW-1:0]   cnt,
    output logic [LEVELS-1:0]           at_lim
);
    logic [LEVELS-1:0] carry;
    assign carry[0] = step;

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        logic [CW-1:0] val;
        assign cnt[g]    = val;
        assign at_lim[g] = (val == lim[g]);

        if (g < LEVELS - 1) begin : g_carry
            assign carry[g+1] = carry[g] && at_lim[g];
        end

        // advance or wrap this level when its carry-in is set
        always_ff @(posedge clk) begin
            if (!rst_n)          val <= '0;
            else if (clear)      val <= '0;
            else if (carry[g])   val <= at_lim[g] ? '0 : val + CW'(1);
        end

        // R10: a level never runs past its limit
        a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(clear)) |-> (val <= lim[g]));
    end
endmodule

// File: rtl/cs_addr_map.sv
// Maps counter state to buffer addresses. It biases the tap coordinate by
// +1 so that padding shows up as 0 or as a value above the dimension, with
// no signed arithmetic. Assumes DIM_W >= 4 so that a tap index fits.
module cs_addr_map
    import cs_pkg::*;
#(
    parameter int DIM_W = 5,
    parameter int FA_W  = 3 * DIM_W,
    parameter int WA_W  = DIM_W + 4
) (
    input  conv_mode_e          mode,
    input  logic [DIM_W-1:0]    tap,
    input  logic [DIM_W-1:0]    ch,
    input  logic [DIM_W-1:0]    col,
    input  logic [DIM_W-1:0]    row,
    input  logic [DIM_W-1:0]    h_dim,
    input  logic [DIM_W-1:0]    w_dim,
    output logic                pad,
    output logic [FA_W-1:0]     fm_addr,
    output logic [WA_W-1:0]     wt_addr
);
    logic [1:0]       ty, tx;
    logic [DIM_W:0]   rb, cb;
    logic [FA_W-1:0]  lin;

    // split the tap index into window row/column (centre for pointwise)
    always_comb begin
        ty = 2'd1;
        tx = 2'd1;
        if (mode != MODE_PW) begin
            case (tap)
                DIM_W'(0): begin ty = 2'd0; tx = 2'd0; end
                DIM_W'(1): begin ty = 2'd0; tx = 2'd1; end
                DIM_W'(2): begin ty = 2'd0; tx = 2'd2; end
                DIM_W'(3): begin ty = 2'd1; tx = 2'd0; end
                DIM_W'(4): begin ty = 2'd1; tx = 2'd1; end
                DIM_W'(5): begin ty = 2'd1; tx = 2'd2; end
                DIM_W'(6): begin ty = 2'd2; tx = 2'd0; end
                DIM_W'(7): begin ty = 2'd2; tx = 2'd1; end
                default:   begin ty = 2'd2; tx = 2'd2; end
            endcase
        end
    end

    // biased coordinates, padding test and linear addresses
    always_comb begin
        rb  = {1'b0, row} + (DIM_W+1)'(ty);
        cb  = {1'b0, col} + (DIM_W+1)'(tx);
        pad = (rb == '0) || (rb > {1'b0, h_dim}) ||
              (cb == '0) || (cb > {1'b0, w_dim});
        lin = FA_W'(ch) * FA_W'(h_dim) * FA_W'(w_dim)
            + FA_W'(rb - (DIM_W+1)'(1)) * FA_W'(w_dim)
            + FA_W'(cb - (DIM_W+1)'(1));
        fm_addr = pad ? '0 : lin;
        wt_addr = (mode == MODE_PW) ? WA_W'(ch)
                                    : WA_W'(ch) * WA_W'(WIN_TAPS) + WA_W'(tap);
    end
endmodule

// File: rtl/cs_operand_seq.sv
// Operand sequencer for pointwise, depthwise and normal convolution.
// It captures the dimensions on start, steps a row/column/channel/tap
// counter nest on each accepted beat and pulses done after the final beat.
// Assumes: C, H, W >= 1 and 1 <= K <= LANES while a run is active.
module cs_operand_seq
    import cs_pkg::*;
#(
    parameter int DIM_W = 5,
    parameter int LANES = 8,
    localparam int LK_W = $clog2(LANES + 1),
    localparam int FA_W = 3 * DIM_W,
    localparam int WA_W = DIM_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         mode_in,
    input  logic [DIM_W-1:0]   c_in,
    input  logic [DIM_W-1:0]   h_in,
    input  logic [DIM_W-1:0]   w_in,
    input  logic [LK_W-1:0]    k_in,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [FA_W-1:0]    fm_addr,
    output logic               fm_rd,
    output logic               fm_zero,
    output logic [WA_W-1:0]    wt_addr,
    output logic [LANES-1:0]   lane_mask,
    output logic               grp_last,
    output logic               done
);
    conv_mode_e               mode_q;
    logic [DIM_W-1:0]         c_q, h_q, w_q;
    logic [LK_W-1:0]          k_q;
    logic                     busy_q, done_q;
    logic [3:0][DIM_W-1:0]    lim, cnt;
    logic [3:0]               at_lim;
    logic                     start_ok, accept, seq_end, pad;

    assign start_ok  = start && !busy_q && (mode_in != MODE_RSV);
    assign accept    = busy_q && out_ready;
    assign seq_end   = &at_lim;
    assign out_valid = busy_q;
    assign done      = done_q;

    // run state and captured dimensions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            mode_q <= MODE_PW;
            c_q    <= '0;
            h_q    <= '0;
            w_q    <= '0;
            k_q    <= '0;
        end else begin
            done_q <= accept && seq_end;
            if (start_ok) begin
                busy_q <= 1'b1;
                mode_q <= conv_mode_e'(mode_in);
                c_q    <= c_in;
                h_q    <= h_in;
                w_q    <= w_in;
                k_q    <= k_in;
            end else if (accept && seq_end) begin
                busy_q <= 1'b0;
            end
        end
    end

    // counter limits: level 0 tap, 1 channel, 2 column, 3 row
    assign lim[0] = (mode_q == MODE_PW) ? '0 : DIM_W'(WIN_TAPS - 1);
    assign lim[1] = c_q - DIM_W'(1);
    assign lim[2] = w_q - DIM_W'(1);
    assign lim[3] = h_q - DIM_W'(1);

    cs_nest_counter #(.LEVELS(4), .CW(DIM_W)) u_nest (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_ok),
        .step   (accept),
        .lim    (lim),
        .cnt    (cnt),
        .at_lim (at_lim)
    );

    cs_addr_map #(.DIM_W(DIM_W), .FA_W(FA_W), .WA_W(WA_W)) u_map (
        .mode    (mode_q),
        .tap     (cnt[0]),
        .ch      (cnt[1]),
        .col     (cnt[2]),
        .row     (cnt[3]),
        .h_dim   (h_q),
        .w_dim   (w_q),
        .pad     (pad),
        .fm_addr (fm_addr),
        .wt_addr (wt_addr)
    );

    assign fm_rd    = busy_q && !pad;
    assign fm_zero  = busy_q && pad;
    // group ends at the last tap; pointwise and normal also need the last channel
    assign grp_last = busy_q && at_lim[0] && ((mode_q == MODE_DW) || at_lim[1]);

    // lane replication: one lane in depthwise, K lanes otherwise
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_mask[i] = busy_q &&
            ((mode_q == MODE_DW) ? (i == 0) : (LK_W'(i) < k_q));
    end

    // R7: a stalled beat holds
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(fm_addr) &&
        $stable(wt_addr) && $stable(grp_last) && $stable(lane_mask) && $stable(fm_rd));

    // R8: done follows an accepted group end and lasts one cycle
    a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready && grp_last));
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: reads stay inside the feature map
    a_r5_read_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fm_rd |-> (int'(fm_addr) < int'(c_q) * int'(h_q) * int'(w_q)));

    // R6: depthwise drives a single lane
    a_r6_dw_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (mode_q == MODE_DW) |-> $countones(lane_mask) == 1);

    // R9: start during a run leaves the captured mode alone
    a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && start |=> $stable(mode_q));
endmodule

// File: tb/tb_cs_operand_seq.sv
// Directed bench for the operand sequencer; drives and samples on falling edges.
module tb_cs_operand_seq;
    localparam int DIM_W = 5;
    localparam int LANES = 8;
    localparam int LK_W  = $clog2(LANES + 1);
    localparam int FA_W  = 3 * DIM_W;
    localparam int WA_W  = DIM_W + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] mode_in = '0;
    logic [DIM_W-1:0] c_in = '0, h_in = '0, w_in = '0;
    logic [LK_W-1:0] k_in = '0;
    logic out_ready = 1'b1;
    logic out_valid, fm_rd, fm_zero, grp_last, done;
    logic [FA_W-1:0] fm_addr;
    logic [WA_W-1:0] wt_addr;
    logic [LANES-1:0] lane_mask;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cs_operand_seq #(.DIM_W(DIM_W), .LANES(LANES)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode_in),
        .c_in(c_in), .h_in(h_in), .w_in(w_in), .k_in(k_in),
        .out_ready(out_ready), .out_valid(out_valid), .fm_addr(fm_addr),
        .fm_rd(fm_rd), .fm_zero(fm_zero), .wt_addr(wt_addr),
        .lane_mask(lane_mask), .grp_last(grp_last), .done(done)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // compare the visible beat with its expected fields
    task automatic check_beat(input string tag, input int efa, input int ewt, input int elast,
                              input int epad, input int emask);
        chk(tag, "out_valid", int'(out_valid), 1);
        chk(tag, "fm_addr", int'(fm_addr), efa);
        chk(tag, "wt_addr", int'(wt_addr), ewt);
        chk(tag, "grp_last", int'(grp_last), elast);
        chk("R5", "fm_zero", int'(fm_zero), epad);
        chk("R5", "fm_rd", int'(fm_rd), 1 - epad);
        chk("R6", "lane_mask", int'(lane_mask), emask);
    endtask

    // one complete run with optional stalls and an ignored mid-run start
    task automatic run_case(input int mode, input int c, input int h, input int w, input int k,
                            input bit stall, input bit poke, input string tag);
        int beats = 0;
        int nt = (mode == 0) ? 1 : 9;
        int emask = (mode == 1) ? 1 : ((1 << k) - 1);
        @(negedge clk);
        start = 1'b1; mode_in = 2'(mode);
        c_in = DIM_W'(c); h_in = DIM_W'(h); w_in = DIM_W'(w); k_in = LK_W'(k);
        out_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                for (int ch = 0; ch < c; ch++) begin
                    for (int t = 0; t < nt; t++) begin
                        int ty = (mode == 0) ? 1 : t / 3;
                        int tx = (mode == 0) ? 1 : t % 3;
                        int ry = y + ty - 1;
                        int rx = x + tx - 1;
                        int epad = (ry < 0 || ry >= h || rx < 0 || rx >= w) ? 1 : 0;
                        int efa = epad ? 0 : ch * h * w + ry * w + rx;
                        int ewt = (mode == 0) ? ch : ch * 9 + t;
                        int elast = (mode == 1) ? int'(t == nt - 1)
                                                : int'(t == nt - 1 && ch == c - 1);
                        if (stall && (beats % 3 == 1)) begin
                            out_ready = 1'b0;
                            check_beat("R7", efa, ewt, elast, epad, emask);
                            @(negedge clk);
                            check_beat("R7", efa, ewt, elast, epad, emask);
                            out_ready = 1'b1;
                        end
                        if (poke && beats == 2) begin
                            // R9: start while busy with other mode and sizes
                            start = 1'b1; mode_in = 2'd1;
                            c_in = DIM_W'(7); h_in = DIM_W'(7); w_in = DIM_W'(7);
                        end
                        check_beat(tag, efa, ewt, elast, epad, emask);
                        @(negedge clk);
                        start = 1'b0;
                        beats++;
                    end
                end
            end
        end
        chk("R8", "done after last", int'(done), 1);
        chk("R10", "valid after last", int'(out_valid), 0);
        @(negedge clk);
        chk("R8", "done one cycle", int'(done), 0);
    endtask

    task automatic test_reset();
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "fm_rd", int'(fm_rd), 0);
        chk("R1", "fm_zero", int'(fm_zero), 0);
        chk("R1", "lane_mask", int'(lane_mask), 0);
    endtask

    task automatic test_reserved_mode();
        @(negedge clk);
        start = 1'b1; mode_in = 2'd3;
        c_in = DIM_W'(2); h_in = DIM_W'(2); w_in = DIM_W'(2); k_in = LK_W'(2);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk("R9", "reserved mode valid", int'(out_valid), 0);
            chk("R9", "reserved mode done", int'(done), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run finished)");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_case(0, 3, 2, 3, 4, 1'b0, 1'b0, "R2");
        run_case(0, 1, 1, 1, 8, 1'b0, 1'b0, "R2");
        run_case(1, 2, 3, 3, 5, 1'b0, 1'b0, "R3");
        run_case(1, 1, 1, 1, 1, 1'b0, 1'b0, "R3");
        run_case(2, 2, 2, 4, 3, 1'b1, 1'b0, "R4");
        run_case(0, 2, 2, 2, 1, 1'b1, 1'b1, "R2");
        test_reserved_mode();
        run_case(2, 3, 3, 2, 8, 1'b0, 1'b0, "R4");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule